// File: doc/BRIEF.md
# Flash Self-Programming Command Controller

This block holds the control and status byte that software uses to start self-programming of on-chip program flash. A CPU-side write arms a command: page erase, page write, a lock/fuse read, or a read-enable that drops the temporary buffer's contents. An armed command is short-lived. It runs only if the matching instruction strobe, SPM for flash operations and LPM for lock/fuse reads, arrives within a fixed number of cycles after the write. Otherwise it disarms itself.

Erase and write requests go to a flash controller port as a one-cycle start pulse with an operation code and a page number. The block then waits for a one-cycle done pulse. The page number is taken from the upper bits of the Z-pointer. The CPU is halted while an erase or write is in progress. Every command bit and the enable bit clear on completion or timeout. A level interrupt request signals that the unit is ready for the next command.

Top module: `flash_selfprog_ctrl`

## Requirements
- R1: After reset, `reg_rdata` reads 0x00 and `cpu_halt`, `fl_start` and `spm_irq` are low.
- R2: Readback is {ie, 0, 0, rdre, lock, pwr, per, en}, with ie at bit 7 and en at bit 0. Bits 6 and 5 always read 0.
- R3: A write of 0x05 (bits 2 and 0, page write) arms a write. An SPM strobe sampled at edges 1 to 4 after the write edge gives, in the next cycle, `fl_start`=1, `fl_cmd`=2'b10 and `fl_page` = zptr[Z_W-1 -: PAGE_AW].
- R4: A write of 0x03 (bits 1 and 0, page erase) behaves as R3 but with `fl_cmd`=2'b01.
- R5: If no SPM strobe arrives, the command bits and the enable bit read 0 from the 4th edge after the write edge. A later strobe issues no request.
- R6: `cpu_halt` is high from the `fl_start` cycle until the cycle in which `fl_done` is sampled. The command bits read 0 once it falls. With a done pulse L+1 cycles after start, halt lasts L+2 cycles.
- R7: A write of 0x09 (bits 3 and 0) arms a lock/fuse read. An LPM strobe sampled at edges 1 to 3 raises `nvm_rd_sel` in the same cycle, with `nvm_rd_lock` = zptr[0] (1 = lock bits, 0 = fuse bits). The bits then clear. A later LPM strobe leaves `nvm_rd_sel` low.
- R8: A write with bit 4 set while `buf_fill_active` is 1 issues `fl_start` with `fl_cmd`=2'b11 and no halt. Bit 4 reads 1 until `fl_done`.
- R9: A write of 0x11 while no buffer fill is active arms a read-enable. An SPM strobe or a timeout clears it without any flash request.
- R10: A write with more than one of bits 4..1 set leaves bits 4..0 unchanged. Bit 7 still takes the written value.
- R11: Bits 3..1 written without bit 0 are ignored.
- R12: `spm_irq` = ie & `glob_ie` & ~en & ~`eep_busy`, and it is low while any flash request is in progress.
- R13: Command writes that arrive while a command is armed or running are ignored, apart from bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register readback |
| glob_ie | input | 1 | Global interrupt flag |
| eep_busy | input | 1 | EEPROM write in progress |
| buf_fill_active | input | 1 | Temporary buffer is being filled |
| spm_stb | input | 1 | Store-to-program-memory instruction strobe |
| lpm_stb | input | 1 | Load-from-program-memory instruction strobe |
| zptr | input | Z_W | Z-pointer value |
| fl_start | output | 1 | One-cycle request to the flash controller |
| fl_cmd | output | 2 | Operation: 01 erase, 10 write, 11 buffer clear |
| fl_page | output | PAGE_AW | Page number for erase or write |
| fl_done | input | 1 | One-cycle completion from the flash controller |
| cpu_halt | output | 1 | Stalls the CPU during erase or write |
| nvm_rd_sel | output | 1 | Current LPM reads lock/fuse bits instead of flash |
| nvm_rd_lock | output | 1 | With nvm_rd_sel: 1 lock bits, 0 fuse bits |
| spm_irq | output | 1 | Ready interrupt request |

## Verification
Erase and write arming is driven with a random strobe delay from 0 to 5 idle cycles, a random flash busy time and a random Z-pointer. Delays of 0 to 3 must issue the request with the right code, page and halt length. Delays of 4 and 5 must issue nothing, which places the window edge exactly. The LPM path is swept over delays on both sides of its shorter window and over both Z-pointer bit 0 values, so lock reads are told apart from fuse reads. Directed writes cover the multi-bit, no-enable, write-while-armed and buffer-fill cases, each of which must leave the request port idle or take the buffer-clear path.

// File: rtl/selfprog_pkg.sv
package selfprog_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE    = 2'b00,
    SQ_ARM_SPM = 2'b01,
    SQ_ARM_LPM = 2'b10,
    SQ_BUSY    = 2'b11
  } sq_state_t;

  typedef enum logic [1:0] {
    FOP_NONE  = 2'b00,
    FOP_ERASE = 2'b01,
    FOP_WRITE = 2'b10,
    FOP_BCLR  = 2'b11
  } fop_t;

  // bit positions in the control byte
  localparam int unsigned CB_IE   = 7;
  localparam int unsigned CB_RDRE = 4;
  localparam int unsigned CB_LOCK = 3;
  localparam int unsigned CB_PWR  = 2;
  localparam int unsigned CB_PER  = 1;
  localparam int unsigned CB_EN   = 0;

  function automatic logic multi_cmd(input logic [3:0] c);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 4; i++) n += int'(c[i]);
    return (n > 1);
  endfunction

endpackage

// File: rtl/selfprog_win_timer.sv
module selfprog_win_timer #(
  parameter int unsigned SPM_WIN = 4,
  parameter int unsigned LPM_WIN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic sel_lpm,
  input  logic run,
  output logic expire
);
  localparam int unsigned MAXW = (SPM_WIN > LPM_WIN) ? SPM_WIN : LPM_WIN;
  localparam int unsigned CW   = $clog2(MAXW + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = sel_lpm ? CW'(LPM_WIN) : CW'(SPM_WIN);
    end else if (run && (cnt_q != '0)) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire = run && (cnt_q == CW'(1));

endmodule

// File: rtl/selfprog_seq.sv
module selfprog_seq
  import selfprog_pkg::*;
#(
  parameter int unsigned Z_W     = 16,
  parameter int unsigned PAGE_AW = 7,
  parameter int unsigned SPM_WIN = 4,
  parameter int unsigned LPM_WIN = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go_spm,
  input  logic               go_lpm,
  input  logic               go_bclr,
  input  fop_t               op_sel,
  input  logic               spm_stb,
  input  logic               lpm_stb,
  input  logic [Z_W-1:0]     zptr,
  input  logic               fl_done,
  output logic               fin,
  output logic               armed,
  output logic               op_active,
  output logic               fl_start,
  output fop_t               fl_cmd,
  output logic [PAGE_AW-1:0] fl_page,
  output logic               halt,
  output logic               nvm_rd_sel,
  output logic               nvm_rd_lock
);
  sq_state_t          st_q, st_d;
  fop_t               pend_q, pend_d;
  fop_t               cmd_q, cmd_d;
  logic               start_q, start_d;
  logic [PAGE_AW-1:0] page_q, page_d;
  logic               tmr_load, tmr_run, tmr_exp;

  selfprog_win_timer #(.SPM_WIN(SPM_WIN), .LPM_WIN(LPM_WIN)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (tmr_load),
    .sel_lpm(go_lpm),
    .run    (tmr_run),
    .expire (tmr_exp)
  );

  assign tmr_load = (st_q == SQ_IDLE) && !go_bclr && (go_spm || go_lpm);
  assign tmr_run  = (st_q == SQ_ARM_SPM) || (st_q == SQ_ARM_LPM);

  always_comb begin
    st_d       = st_q;
    pend_d     = pend_q;
    cmd_d      = cmd_q;
    page_d     = page_q;
    start_d    = 1'b0;
    fin        = 1'b0;
    nvm_rd_sel = 1'b0;
    case (st_q)
      SQ_IDLE: begin
        if (go_bclr) begin
          st_d    = SQ_BUSY;
          start_d = 1'b1;
          cmd_d   = FOP_BCLR;
        end else if (go_spm) begin
          st_d   = SQ_ARM_SPM;
          pend_d = op_sel;
        end else if (go_lpm) begin
          st_d = SQ_ARM_LPM;
        end
      end
      SQ_ARM_SPM: begin
        if (spm_stb) begin
          if ((pend_q == FOP_ERASE) || (pend_q == FOP_WRITE)) begin
            st_d    = SQ_BUSY;
            start_d = 1'b1;
            cmd_d   = pend_q;
            page_d  = zptr[Z_W-1 -: PAGE_AW];
          end else begin
            st_d = SQ_IDLE;
            fin  = 1'b1;
          end
        end else if (tmr_exp) begin
          st_d = SQ_IDLE;
          fin  = 1'b1;
        end
      end
      SQ_ARM_LPM: begin
        if (lpm_stb) begin
          nvm_rd_sel = 1'b1;
          st_d       = SQ_IDLE;
          fin        = 1'b1;
        end else if (tmr_exp) begin
          st_d = SQ_IDLE;
          fin  = 1'b1;
        end
      end
      default: begin
        if (fl_done) begin
          st_d  = SQ_IDLE;
          fin   = 1'b1;
          cmd_d = FOP_NONE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      pend_q  <= FOP_NONE;
      cmd_q   <= FOP_NONE;
      start_q <= 1'b0;
      page_q  <= '0;
    end else begin
      st_q    <= st_d;
      pend_q  <= pend_d;
      cmd_q   <= cmd_d;
      start_q <= start_d;
      page_q  <= page_d;
    end
  end

  assign armed       = tmr_run;
  assign op_active   = (st_q == SQ_BUSY);
  assign halt        = op_active && ((cmd_q == FOP_ERASE) || (cmd_q == FOP_WRITE));
  assign fl_start    = start_q;
  assign fl_cmd      = cmd_q;
  assign fl_page     = page_q;
  assign nvm_rd_lock = nvm_rd_sel && zptr[0];

endmodule

// File: rtl/flash_selfprog_ctrl.sv
module flash_selfprog_ctrl
  import selfprog_pkg::*;
#(
  parameter int unsigned Z_W     = 16,
  parameter int unsigned PAGE_AW = 7,
  parameter int unsigned SPM_WIN = 4,
  parameter int unsigned LPM_WIN = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  input  logic               glob_ie,
  input  logic               eep_busy,
  input  logic               buf_fill_active,
  input  logic               spm_stb,
  input  logic               lpm_stb,
  input  logic [Z_W-1:0]     zptr,
  output logic               fl_start,
  output logic [1:0]         fl_cmd,
  output logic [PAGE_AW-1:0] fl_page,
  input  logic               fl_done,
  output logic               cpu_halt,
  output logic               nvm_rd_sel,
  output logic               nvm_rd_lock,
  output logic               spm_irq
);
  logic       ie_q, ie_d;
  logic [3:0] cmd_q, cmd_d;   // bits 4..1
  logic       en_q, en_d;
  logic [3:0] wr_cmd;
  logic       wr_en, cmd_ok;
  logic       go_spm, go_lpm, go_bclr;
  logic       fin, armed, op_active;
  fop_t       op_sel, cmd_out;

  assign wr_cmd  = reg_wdata[CB_RDRE:CB_PER];
  assign wr_en   = reg_wdata[CB_EN];
  assign cmd_ok  = reg_wr && !armed && !op_active && !multi_cmd(wr_cmd);
  assign go_bclr = cmd_ok && reg_wdata[CB_RDRE] && buf_fill_active;
  assign go_lpm  = cmd_ok && wr_en && reg_wdata[CB_LOCK] && !go_bclr;
  assign go_spm  = cmd_ok && wr_en && !reg_wdata[CB_LOCK] && !go_bclr;

  always_comb begin
    if (reg_wdata[CB_PWR])      op_sel = FOP_WRITE;
    else if (reg_wdata[CB_PER]) op_sel = FOP_ERASE;
    else                        op_sel = FOP_NONE;
  end

  always_comb begin
    ie_d  = reg_wr ? reg_wdata[CB_IE] : ie_q;
    cmd_d = cmd_q;
    en_d  = en_q;
    if (fin) begin
      cmd_d = '0;
      en_d  = 1'b0;
    end else if (go_spm || go_lpm || go_bclr) begin
      cmd_d = wr_cmd;
      en_d  = wr_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q  <= 1'b0;
      cmd_q <= '0;
      en_q  <= 1'b0;
    end else begin
      ie_q  <= ie_d;
      cmd_q <= cmd_d;
      en_q  <= en_d;
    end
  end

  selfprog_seq #(
    .Z_W(Z_W), .PAGE_AW(PAGE_AW), .SPM_WIN(SPM_WIN), .LPM_WIN(LPM_WIN)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_spm     (go_spm),
    .go_lpm     (go_lpm),
    .go_bclr    (go_bclr),
    .op_sel     (op_sel),
    .spm_stb    (spm_stb),
    .lpm_stb    (lpm_stb),
    .zptr       (zptr),
    .fl_done    (fl_done),
    .fin        (fin),
    .armed      (armed),
    .op_active  (op_active),
    .fl_start   (fl_start),
    .fl_cmd     (cmd_out),
    .fl_page    (fl_page),
    .halt       (cpu_halt),
    .nvm_rd_sel (nvm_rd_sel),
    .nvm_rd_lock(nvm_rd_lock)
  );

  assign fl_cmd    = cmd_out;
  assign reg_rdata = {ie_q, 2'b00, cmd_q, en_q};
  assign spm_irq   = ie_q && glob_ie && !en_q && !eep_busy && !op_active;

endmodule

// File: rtl/selfprog_chk.sv
module selfprog_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] reg_rdata,
  input logic       spm_stb,
  input logic       lpm_stb,
  input logic       glob_ie,
  input logic       eep_busy,
  input logic       fl_start,
  input logic [1:0] fl_cmd,
  input logic       fl_done,
  input logic       cpu_halt,
  input logic       nvm_rd_sel,
  input logic       spm_irq
);
  AST_RO_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[6:5] == 2'b00); // R2

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fl_start |=> !fl_start); // R3

  AST_START_AFTER_SPM: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_start && fl_cmd != 2'b11) |-> $past(spm_stb)); // R4

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_halt && !fl_done) |=> cpu_halt); // R6

  AST_SEL_NEEDS_LPM: assert property (@(posedge clk) disable iff (!rst_n)
    nvm_rd_sel |-> lpm_stb); // R7

  AST_BCLR_NO_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_start && fl_cmd == 2'b11) |-> !cpu_halt); // R8

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    spm_irq |-> (reg_rdata[7] && !reg_rdata[0] && glob_ie && !eep_busy)); // R12

  AST_IRQ_NOT_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_halt |-> !spm_irq); // R12
endmodule

bind flash_selfprog_ctrl selfprog_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_rdata (reg_rdata),
  .spm_stb   (spm_stb),
  .lpm_stb   (lpm_stb),
  .glob_ie   (glob_ie),
  .eep_busy  (eep_busy),
  .fl_start  (fl_start),
  .fl_cmd    (fl_cmd),
  .fl_done   (fl_done),
  .cpu_halt  (cpu_halt),
  .nvm_rd_sel(nvm_rd_sel),
  .spm_irq   (spm_irq)
);

// File: tb/flash_selfprog_ctrl_tb_top.sv
module flash_selfprog_ctrl_tb_top;
  localparam int Z_W = 16;
  localparam int PAGE_AW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic glob_ie = 1'b0, eep_busy = 1'b0, buf_fill_active = 1'b0;
  logic spm_stb = 1'b0, lpm_stb = 1'b0;
  logic [Z_W-1:0] zptr = '0;
  logic fl_start, fl_done, cpu_halt, nvm_rd_sel, nvm_rd_lock, spm_irq;
  logic [1:0] fl_cmd;
  logic [PAGE_AW-1:0] fl_page;

  int nvec = 0;
  int nfail = 0;
  int fl_lat = 2;
  int mcnt = 0;
  int start_cnt = 0;
  logic done_r = 1'b0;

  always #2 clk = ~clk;

  flash_selfprog_ctrl #(.Z_W(Z_W), .PAGE_AW(PAGE_AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .glob_ie(glob_ie), .eep_busy(eep_busy),
    .buf_fill_active(buf_fill_active), .spm_stb(spm_stb), .lpm_stb(lpm_stb),
    .zptr(zptr), .fl_start(fl_start), .fl_cmd(fl_cmd), .fl_page(fl_page),
    .fl_done(fl_done), .cpu_halt(cpu_halt), .nvm_rd_sel(nvm_rd_sel),
    .nvm_rd_lock(nvm_rd_lock), .spm_irq(spm_irq)
  );

  // flash controller model: done pulse fl_lat+1 cycles after start
  always @(posedge clk) begin
    if (fl_start) begin
      mcnt      <= fl_lat;
      start_cnt <= start_cnt + 1;
      done_r    <= 1'b0;
    end else begin
      done_r <= (mcnt == 1);
      if (mcnt > 0) mcnt <= mcnt - 1;
    end
  end
  assign fl_done = done_r;

  function automatic logic [6:0] page_of(input logic [15:0] z);
    return z[15:9];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
  endtask

  // write/erase arming with strobe after d idle cycles
  task automatic spm_case(input bit is_wr, input int d, input int lat, input logic [15:0] z);
    int s0, n;
    logic [7:0] cmd;
    cmd = is_wr ? 8'h05 : 8'h03;
    fl_lat = lat; zptr = z;
    s0 = start_cnt;
    wr(cmd);
    check(is_wr ? "R3 armed readback" : "R4 armed readback", reg_rdata, cmd);
    idle(d);
    spm_stb = 1'b1;
    @(negedge clk); spm_stb = 1'b0;
    if (d <= 3) begin
      check(is_wr ? "R3 start" : "R4 start", fl_start, 1);
      check(is_wr ? "R3 cmd" : "R4 cmd", fl_cmd, is_wr ? 2'b10 : 2'b01);
      check(is_wr ? "R3 page" : "R4 page", fl_page, page_of(z));
      n = 0;
      while (cpu_halt && n < 100) begin n++; @(negedge clk); end
      check("R6 halt length", n, lat + 2);
      check("R6 bits cleared", reg_rdata, 0);
      check("R3 one request", start_cnt - s0, 1);
    end else begin
      idle(3);
      check("R5 no request after window", start_cnt - s0, 0);
      check("R5 bits cleared", reg_rdata, 0);
      check("R5 no halt", cpu_halt, 0);
    end
  endtask

  task automatic lpm_case(input int d, input logic z0);
    wr(8'h09);
    idle(d);
    lpm_stb = 1'b1; zptr[0] = z0;
    #1;
    check("R7 read select", nvm_rd_sel, (d <= 2));
    check("R7 lock/fuse", nvm_rd_lock, (d <= 2) && z0);
    @(negedge clk); lpm_stb = 1'b0;
    check("R7 bits cleared", reg_rdata, 0);
  endtask

  initial begin
    #(4 * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int s0, n;
    void'($urandom(32'h5eed1234));
    idle(3);
    check("R1 rdata", reg_rdata, 0);
    check("R1 halt", cpu_halt, 0);
    check("R1 start", fl_start, 0);
    check("R1 irq", spm_irq, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);

    // R2 / R10: multi-command write, only bit 7 lands
    s0 = start_cnt;
    wr(8'hFF);
    check("R10 R2 multi write", reg_rdata, 8'h80);
    wr(8'h07);
    idle(5);
    check("R10 multi write no-op", reg_rdata, 8'h00);
    check("R10 no request", start_cnt - s0, 0);

    // R11: command bit without enable
    wr(8'h04);
    check("R11 no enable", reg_rdata, 8'h00);
    idle(5);
    check("R11 no request", start_cnt - s0, 0);

    // R5: exact timeout edge
    wr(8'h05);
    idle(3);
    check("R5 still armed at edge 3", reg_rdata, 8'h05);
    idle(1);
    check("R5 cleared at edge 4", reg_rdata, 8'h00);

    // directed window edges
    spm_case(1'b1, 0, 1, 16'hFFFF);
    spm_case(1'b0, 3, 3, 16'h0200);
    spm_case(1'b1, 4, 2, 16'h1234);

    // R13: second command while armed is ignored
    fl_lat = 2; zptr = 16'hA400;
    wr(8'h05);
    wr(8'h03);
    check("R13 armed keeps command", reg_rdata, 8'h05);
    spm_stb = 1'b1; @(negedge clk); spm_stb = 1'b0;
    check("R13 write kept", fl_cmd, 2'b10);
    wr(8'h03);
    check("R13 write while busy ignored", reg_rdata, 8'h05);
    idle(6);
    check("R13 done", reg_rdata, 8'h00);

    // R7 lock/fuse read windows
    for (int d = 0; d < 5; d++) lpm_case(d, d[0]);
    lpm_case(1, 1'b1);
    lpm_case(2, 1'b0);

    // R9: read-enable with no fill active
    s0 = start_cnt;
    wr(8'h11);
    check("R9 armed", reg_rdata, 8'h11);
    spm_stb = 1'b1; @(negedge clk); spm_stb = 1'b0;
    check("R9 consumed", reg_rdata, 8'h00);
    wr(8'h11);
    idle(5);
    check("R9 timed out", reg_rdata, 8'h00);
    check("R9 no request", start_cnt - s0, 0);

    // R8: buffer clear while fill active
    buf_fill_active = 1'b1; fl_lat = 3;
    wr(8'h10);
    check("R8 start", fl_start, 1);
    check("R8 cmd", fl_cmd, 2'b11);
    check("R8 no halt", cpu_halt, 0);
    check("R8 bit4 held", reg_rdata, 8'h10);
    n = 0;
    while (reg_rdata[4] && n < 100) begin n++; @(negedge clk); end
    check("R8 clear duration", n, 5);
    buf_fill_active = 1'b0;

    // R12 interrupt gating
    glob_ie = 1'b1;
    wr(8'h80);
    check("R12 irq on", spm_irq, 1);
    eep_busy = 1'b1; #1;
    check("R12 eeprom busy", spm_irq, 0);
    eep_busy = 1'b0; glob_ie = 1'b0; #1;
    check("R12 global off", spm_irq, 0);
    glob_ie = 1'b1;
    wr(8'h81);
    check("R12 enable set", spm_irq, 0);
    idle(4);
    check("R12 after timeout", spm_irq, 1);
    buf_fill_active = 1'b1; fl_lat = 4;
    wr(8'h90);
    check("R12 op in progress", spm_irq, 0);
    idle(8);
    buf_fill_active = 1'b0;
    check("R12 after clear", spm_irq, 1);
    wr(8'h00);

    // random erase/write arming
    for (int i = 0; i < 60; i++) begin
      spm_case($urandom_range(0, 1) == 1, int'($urandom_range(0, 5)),
               int'($urandom_range(1, 6)), 16'($urandom));
    end

    summary();
    $finish;
  end
endmodule